// File: doc/BRIEF.md
# Bit-Serial Eight-Tap FIR Filter

This block is a finite-impulse-response filter whose multiplies and adds all work one bit per clock. A signed sample is presented on a parallel port together with a load strobe. The control unit takes that sample at the next word boundary and turns it into a sign-extended serial word, least significant bit first. The word then passes down a chain of word-length delay lines. Every tap has its own serial-by-parallel multiplier, which holds that tap's signed coefficient. The tap products are merged by a balanced tree of serial adders. The serial sum is collected back into a parallel result, which is presented with a one-clock valid pulse.

One sample takes a fixed word frame of `SAMP_W + COEF_W + 1 + log2(TAPS)` clocks. With the default parameters this is 20 clocks, so the filter produces one result every 20 clocks. The frame counter only runs while there is work to do. When no sample is waiting, the filter idles and its history stays frozen. Coefficients are written through a tap-select plus value port into a shadow bank. The working bank is copied from the shadow bank only at a word boundary.

Top module: `fir_bs_filter`

## Requirements
- R1: After reset `out_valid` is 0, `out_result` is 0, the filter is idle and every stored past sample is treated as 0.
- R2: When `in_load` is sampled high while the filter is idle, the word frame starts on the second rising edge, and `out_valid` is high after the 22nd rising edge, counting the edge that sampled the strobe as the first.
- R3: Each result equals the sum over taps k = 0..7 of coef[k] × x[n−k], where x[n] is the sample of the current frame and x[n−k] is the sample of the k-th earlier frame. All values are two's complement, and the sum is taken modulo 2^16.
- R4: When a new sample is already waiting at the last clock of a frame, the next frame starts without a gap, so `out_valid` pulses exactly 20 clocks apart.
- R5: A load strobe that arrives during a frame is held and starts the next frame at the boundary. If several strobes arrive before the boundary, only the last one is used.
- R6: A coefficient write (`coef_sel` selects the tap, `coef_data` is the signed value) reaches the working bank only at a word boundary, or on the next clock when the filter is idle. A frame in progress always uses the coefficients it started with.
- R7: `out_valid` is a one-clock pulse on the clock after the last frame cycle, and `out_result` keeps its value until the next pulse.
- R8: Extreme operands (−128 and 127 in samples and coefficients) produce the exact product bits. When the tap sum overflows, the result wraps modulo 2^16.
- R9: While no sample is loaded, no frame runs and the delay lines do not move, so an idle gap of any length leaves the filter history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_load | input | 1 | Sample strobe |
| in_sample | input | 8 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_sel | input | 3 | Tap index of the coefficient write |
| coef_data | input | 8 | Signed coefficient value |
| out_valid | output | 1 | One-clock result strobe |
| out_result | output | 16 | Signed filter result |

## Verification
A strobe sampled while the filter is idle yields its result 22 edges later. During streaming, results are due every 20 edges. A coefficient write reaches the working bank on the edge that starts the next frame, or on the very next edge when the filter is idle. The bench replays the strobe hold, the boundary copy of the coefficients and the frame counter in a behavioural model that advances on every rising edge. It compares both outputs at the following falling edge, so every expected value is due in the exact cycle where it is checked. Separate checks count edges from an idle strobe to the valid pulse, and measure the spacing of consecutive pulses while the filter streams.

// File: rtl/fir_bs_pkg.sv
package fir_bs_pkg;

  localparam int DEF_TAPS   = 8;
  localparam int DEF_SAMP_W = 8;
  localparam int DEF_COEF_W = 8;

  // clocks per word: product bits + multiplier latency + tree depth
  function automatic int frame_len(int sw, int cw, int taps);
    return sw + cw + 1 + $clog2(taps);
  endfunction

  // tree level of adder j when adders consume node pairs in order
  function automatic int adder_level(int j, int taps);
    int lvl;
    int bound;
    lvl   = 0;
    bound = taps / 2;
    while (j >= bound) begin
      lvl   = lvl + 1;
      bound = bound + (taps >> (lvl + 1));
    end
    return lvl;
  endfunction

  function automatic logic fa_sum(logic a, logic b, logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(logic a, logic b, logic c);
    return (a & b) | (c & (a ^ b));
  endfunction

endpackage

// File: rtl/fir_bs_ctrl.sv
module fir_bs_ctrl #(
  parameter int FRAME  = 20,
  parameter int SAMP_W = 8,
  parameter int CNT_W  = $clog2(FRAME)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SAMP_W-1:0] data_i,
  output logic              start_o,
  output logic              pend_o,
  output logic              act_o,
  output logic              last_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              xbit_o
);
  logic [SAMP_W-1:0] hold_q;
  logic [SAMP_W-1:0] shf_q;
  logic              pend_q;
  logic              act_q;
  logic [CNT_W-1:0]  cnt_q;

  assign last_o  = act_q && (cnt_q == CNT_W'(FRAME - 1));
  assign start_o = pend_q && (!act_q || last_o);
  assign pend_o  = pend_q;
  assign act_o   = act_q;
  assign cnt_o   = cnt_q;
  assign xbit_o  = shf_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      shf_q  <= '0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (load_i) hold_q <= data_i;
      pend_q <= start_o ? load_i : (pend_q | load_i);
      if (start_o) begin
        act_q <= 1'b1;
        cnt_q <= '0;
        shf_q <= hold_q;
      end else if (act_q) begin
        // arithmetic shift keeps emitting the sign bit past the MSB
        shf_q <= {shf_q[SAMP_W-1], shf_q[SAMP_W-1:1]};
        if (last_o) act_q <= 1'b0;
        else        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fir_bs_spm.sv
module fir_bs_spm #(
  parameter int COEF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic [COEF_W-1:0] coef,
  input  logic              x,
  output logic              p
);
  logic [COEF_W-1:0] acc_q;
  logic [COEF_W:0]   sum_w;

  // shift-add step: add the coefficient when the serial bit is set,
  // emit the low bit, keep the rest arithmetically shifted down
  always_comb begin
    sum_w = (clr ? {(COEF_W+1){1'b0}} : {acc_q[COEF_W-1], acc_q})
          + (x   ? {coef[COEF_W-1], coef} : {(COEF_W+1){1'b0}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      p     <= 1'b0;
    end else if (en) begin
      acc_q <= sum_w[COEF_W:1];
      p     <= sum_w[0];
    end
  end
endmodule

// File: rtl/fir_bs_sadd.sv
module fir_bs_sadd
  import fir_bs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic a,
  input  logic b,
  output logic s
);
  logic cy_q;
  logic cin;

  assign cin = clr ? 1'b0 : cy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cy_q <= 1'b0;
      s    <= 1'b0;
    end else if (en) begin
      cy_q <= fa_carry(a, b, cin);
      s    <= fa_sum(a, b, cin);
    end
  end
endmodule

// File: rtl/fir_bs_filter.sv
module fir_bs_filter
  import fir_bs_pkg::*;
#(
  parameter int  TAPS   = DEF_TAPS,
  parameter int  SAMP_W = DEF_SAMP_W,
  parameter int  COEF_W = DEF_COEF_W,
  localparam int SEL_W  = $clog2(TAPS),
  localparam int PROD_W = SAMP_W + COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_load,
  input  logic [SAMP_W-1:0] in_sample,
  input  logic              coef_we,
  input  logic [SEL_W-1:0]  coef_sel,
  input  logic [COEF_W-1:0] coef_data,
  output logic              out_valid,
  output logic [PROD_W-1:0] out_result
);
  localparam int LVL   = $clog2(TAPS);
  localparam int FRAME = frame_len(SAMP_W, COEF_W, TAPS);
  localparam int CNT_W = $clog2(FRAME);
  localparam int NODES = 2 * TAPS - 1;

  // control events, named for the checker
  logic             frm_start;
  logic             frm_pend;
  logic             frm_act;
  logic             frm_last;
  logic [CNT_W-1:0] frm_cnt;
  logic             frm_bound;
  logic             xbit;

  fir_bs_ctrl #(.FRAME(FRAME), .SAMP_W(SAMP_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_i(in_load), .data_i(in_sample),
    .start_o(frm_start), .pend_o(frm_pend), .act_o(frm_act),
    .last_o(frm_last), .cnt_o(frm_cnt), .xbit_o(xbit)
  );

  assign frm_bound = !frm_act || frm_last;

  // coefficient shadow bank and working bank
  logic [TAPS-1:0][COEF_W-1:0] coef_sh;
  logic [TAPS-1:0][COEF_W-1:0] coef_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_sh <= '0;
      coef_q  <= '0;
    end else begin
      if (frm_bound) coef_q <= coef_sh;
      if (coef_we)   coef_sh[coef_sel] <= coef_data;
    end
  end

  // word delay chain and per-tap multipliers
  logic [TAPS-1:0]  tapx;
  logic [NODES-1:0] node;

  assign tapx[0] = xbit;

  for (genvar k = 0; k < TAPS - 1; k++) begin : g_dly
    logic [FRAME-1:0] dly_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       dly_q <= '0;
      else if (frm_act) dly_q <= {tapx[k], dly_q[FRAME-1:1]};
    end
    assign tapx[k+1] = dly_q[0];
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    fir_bs_spm #(.COEF_W(COEF_W)) u_spm (
      .clk(clk), .rst_n(rst_n), .en(frm_act),
      .clr(frm_act && frm_cnt == '0),
      .coef(coef_q[k]), .x(tapx[k]), .p(node[k])
    );
  end

  // balanced serial adder tree; level l sees bit 0 at frame clock l+1
  for (genvar j = 0; j < TAPS - 1; j++) begin : g_add
    localparam int LV = adder_level(j, TAPS);
    fir_bs_sadd u_add (
      .clk(clk), .rst_n(rst_n), .en(frm_act),
      .clr(frm_act && frm_cnt == CNT_W'(LV + 1)),
      .a(node[2*j]), .b(node[2*j+1]), .s(node[TAPS+j])
    );
  end

  logic tree_bit;
  assign tree_bit = node[NODES-1];

  // serial-to-parallel capture of result bits 0..PROD_W-2
  logic [PROD_W-2:0] osr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osr_q      <= '0;
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= frm_last;
      if (frm_last)
        out_result <= {tree_bit, osr_q};
      else if (frm_act && frm_cnt >= CNT_W'(LVL + 1))
        osr_q <= {tree_bit, osr_q[PROD_W-2:1]};
    end
  end
endmodule

// File: rtl/fir_bs_chk.sv
module fir_bs_chk #(
  parameter int TAPS   = 8,
  parameter int COEF_W = 8,
  parameter int PROD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_load,
  input logic                     frm_start,
  input logic                     frm_pend,
  input logic                     frm_act,
  input logic                     frm_last,
  input logic [CNT_W-1:0]         frm_cnt,
  input logic [TAPS*COEF_W-1:0]   coef_q,
  input logic                     out_valid,
  input logic [PROD_W-1:0]        out_result
);
  // R2
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_act && !frm_last |=> frm_act && (frm_cnt == $past(frm_cnt) + CNT_W'(1)));

  // R5
  start_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> frm_pend);

  // R5
  load_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_load && !frm_start |=> frm_pend);

  // R6
  coef_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_act && !frm_last |=> $stable(coef_q));

  // R7
  valid_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(frm_last));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result));

  // R9
  idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_act && !frm_start |=> !frm_act);
endmodule

bind fir_bs_filter fir_bs_chk #(
  .TAPS(TAPS), .COEF_W(COEF_W), .PROD_W(PROD_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_load(in_load),
  .frm_start(frm_start), .frm_pend(frm_pend), .frm_act(frm_act),
  .frm_last(frm_last), .frm_cnt(frm_cnt), .coef_q(coef_q),
  .out_valid(out_valid), .out_result(out_result)
);

// File: tb/fir_bs_filter_tb.sv
module fir_bs_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_load = 1'b0;
  logic [7:0]  in_sample = '0;
  logic        coef_we = 1'b0;
  logic [2:0]  coef_sel = '0;
  logic [7:0]  coef_data = '0;
  logic        out_valid;
  logic [15:0] out_result;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  fir_bs_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_load(in_load), .in_sample(in_sample),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_data(coef_data),
    .out_valid(out_valid), .out_result(out_result)
  );

  // behavioural model state
  int          m_act, m_cnt, m_pend, m_hold;
  int          m_shadow[8];
  int          m_coef[8];
  int          m_hist[8];
  logic [15:0] m_res, m_y;
  logic        m_valid;
  int          cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit bnd, start;
    int acc;
    bnd = (m_act == 0) || (m_cnt == 19);
    m_valid = (m_act != 0) && (m_cnt == 19);
    if (m_valid) m_y = m_res;
    if (bnd) for (int k = 0; k < 8; k++) m_coef[k] = m_shadow[k];
    start = bnd && (m_pend != 0);
    if (start) begin
      for (int k = 7; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = m_hold;
      acc = 0;
      for (int k = 0; k < 8; k++) acc += m_coef[k] * m_hist[k];
      m_res = 16'(acc);
      m_act = 1;
      m_cnt = 0;
      m_pend = in_load ? 1 : 0;
    end else begin
      if (m_act != 0) begin
        if (m_cnt == 19) m_act = 0;
        else m_cnt++;
      end
      if (in_load) m_pend = 1;
    end
    if (in_load) m_hold = int'($signed(in_sample));
    if (coef_we) m_shadow[coef_sel] = int'($signed(coef_data));
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    model_step();
    @(negedge clk);
    chk(out_valid == m_valid, (phase == "R3") ? "R7" : phase, "out_valid",
        int'(out_valid), int'(m_valid));
    chk(out_result == m_y, (phase == "R7") ? "R3" : phase, "out_result",
        int'($signed(out_result)), int'($signed(m_y)));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic load(input int v);
    in_load = 1'b1;
    in_sample = 8'(v);
    tick();
    in_load = 1'b0;
  endtask

  task automatic wcoef(input int idx, input int v);
    coef_we = 1'b1;
    coef_sel = 3'(idx);
    coef_data = 8'(v);
    tick();
    coef_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, last_v, gaps;
    m_act = 0; m_cnt = 0; m_pend = 0; m_hold = 0;
    m_res = '0; m_y = '0; m_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      m_shadow[k] = 0; m_coef[k] = 0; m_hist[k] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
    chk(out_result == 16'd0, "R1", "result after reset", int'(out_result), 0);
    rst_n = 1'b1;
    idle(3);

    phase = "R6";
    for (int k = 0; k < 8; k++) wcoef(k, (k % 2 == 0) ? (k + 1) : -(k + 1));
    idle(2);

    // R2: latency from an idle strobe to the valid pulse
    phase = "R2";
    in_load = 1'b1; in_sample = 8'd1;
    lat = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      in_load = 1'b0;
      lat++;
      if (out_valid) break;
    end
    chk(lat == 22, "R2", "edges to valid", lat, 22);

    // R3: impulse response then varied samples
    phase = "R3";
    for (int i = 0; i < 8; i++) begin load(0); idle(24); end
    for (int i = 0; i < 6; i++) begin load(i * 37 - 90); idle(21); end

    // R5: strobes during a frame are held; last one wins
    phase = "R5";
    load(11); idle(4); load(-7); idle(3); load(55); idle(2); load(-100);
    idle(60);

    // R4: continuous strobe, results every 20 clocks
    phase = "R4";
    last_v = -1; gaps = 0;
    for (int i = 0; i < 130; i++) begin
      in_load = 1'b1; in_sample = 8'(i * 13 - 60);
      tick();
      if (out_valid) begin
        if (last_v >= 0) begin
          chk(cyc - last_v == 20, "R4", "valid spacing", cyc - last_v, 20);
          gaps++;
        end
        last_v = cyc;
      end
    end
    in_load = 1'b0;
    chk(gaps >= 4, "R4", "pulses seen", gaps, 4);
    idle(45);

    // R6: coefficient writes in the middle of a frame
    phase = "R6";
    load(100); idle(5); wcoef(0, -50); wcoef(3, 77); idle(3);
    load(-33); idle(8); wcoef(7, 120); idle(50);

    // R8: extreme operands and wraparound
    phase = "R8";
    for (int k = 0; k < 8; k++) wcoef(k, -128);
    for (int i = 0; i < 9; i++) begin load(-128); idle(19); end
    for (int k = 0; k < 8; k++) wcoef(k, (k < 4) ? 127 : -128);
    for (int i = 0; i < 9; i++) begin load((i % 2 == 0) ? 127 : -128); idle(19); end
    idle(30);

    // R9: long idle gap keeps the history
    phase = "R9";
    idle(300);
    load(5); idle(25); load(-3); idle(25);

    phase = "R7";
    idle(10);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule